// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block connects a simple host request port to an asynchronous DRAM that has a 16-bit data bus, separate strobes for the low and high byte, and a 10-bit address bus shared by row and column. The host offers one request at a time with a valid/ready handshake. Each request carries a direction, a 20-bit word address, write data and two byte enables. The controller turns each request into row and column strobe sequences on the memory pins.

After an access the row stays open. If the next request falls in the same row, only a new column strobe is issued. A request to a different row first closes the page and precharges. A pulse on the refresh input is held as pending. At the next safe point the controller closes any open page, precharges, and runs a refresh in which the column strobes go low before the row strobe. No row address is used for this refresh because the memory's own counter supplies it.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is low and in the cycle after it, the row strobe, both column strobes and write enable are high, data output enable is low and read-valid is low.
- R2: Host address bits [19:10] appear on the memory address bus when the row strobe falls. Bits [9:0] appear there when a column strobe falls. A word written to an address is returned by a later read of that address.
- R3: A request whose row equals the open row produces column strobes only, with no new falling edge of the row strobe.
- R4: A request to a different row raises the row strobe, precharges, and then opens the new row with exactly one new falling edge of the row strobe.
- R5: Byte enable bit 0 drives the low column strobe (data bits 7:0) and bit 1 drives the high column strobe (data bits 15:8). A write with one enable leaves the other byte of the stored word unchanged.
- R6: Returned read data carries zero in any byte whose enable was low in the request.
- R7: Each read produces exactly one read-valid pulse, one cycle long. A write produces none.
- R8: A refresh lowers both column strobes before the row strobe falls. It raises the row strobe and both column strobes in the same cycle, and it leaves the page closed, so the next access opens a row again.
- R9: From the cycle after a refresh pulse until the refresh and its precharge are done, request-ready stays low.
- R10: The row strobe stays high for at least T_RP cycles before it falls. At least T_RCD cycles separate the row strobe falling from the first column strobe falling. A column strobe stays low for at least T_CAS cycles.
- R11: Data output enable and the low write enable are asserted only together, and only while a column strobe of a write is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request offered |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address: row in [19:10], column in [9:0] |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| refresh_req | input | 1 | Pulse that schedules one refresh |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read data |
| rd_data | output | 16 | Read data, disabled bytes zero |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_casl_n | output | 1 | Low-byte column strobe, active low |
| mem_cash_n | output | 1 | High-byte column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 10 | Multiplexed row/column address |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Output enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The bench connects a behavioural memory model that latches row and column on strobe edges and stores bytes by lane. It runs a request table that mixes a first access from idle, same-row writes and reads (hits), and moves between two rows (misses). The count of falling row strobes per request shows whether the hit/miss logic chose the right path. Single-byte writes, followed by full-word reads, show whether lane masking on write works. Single-byte reads of words with both bytes set show whether read masking works. A directed refresh, issued while a row is open, shows the strobe order of the refresh, the ready gap, and that a later access to the formerly open row reopens it.

// File: rtl/fpm_pkg.sv
// Package: shared state encodings for the page mode DRAM controller.
// Assumes: used by fpm_seq only; no parameters depend on it.
package fpm_pkg;

    typedef enum logic [2:0] {
        S_IDLE,  // precharged, no row open
        S_PRE,   // row strobe high, precharge wait
        S_ACT,   // row strobe low, row-to-column wait
        S_CAS,   // column strobe(s) low
        S_CP,    // column strobe high, column precharge
        S_OPEN,  // row open, waiting for work
        S_RCAS,  // refresh: column strobes low, row strobe high
        S_RRAS   // refresh: all strobes low
    } fpm_state_t;

    typedef enum logic [1:0] {
        TGT_IDLE,
        TGT_ACT,
        TGT_REF
    } pre_tgt_t;

endpackage

// File: rtl/fpm_wait_cnt.sv
// Module: down-counter for the timing waits of the controller.
// load sets the count; done is high when the count reaches zero.
// Assumes: a state that lasts N cycles loads N-1 on entry.
module fpm_wait_cnt #(
    parameter int CW      = 4,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    // Count down to zero, or reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CW'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/fpm_page_track.sv
// Module: remembers which row is open and flags requests that hit it.
// Assumes: open_set and open_clr are never high in the same cycle.
module fpm_page_track #(
    parameter int ROW_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                open_set,
    input  logic                open_clr,
    input  logic [ROW_BITS-1:0] set_row,
    input  logic [ROW_BITS-1:0] req_row,
    output logic                page_hit
);
    logic                row_vld_q;
    logic [ROW_BITS-1:0] row_q;

    // Track the open row and whether it is still valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_vld_q <= 1'b0;
            row_q     <= '0;
        end else if (open_set) begin
            row_vld_q <= 1'b1;
            row_q     <= set_row;
        end else if (open_clr) begin
            row_vld_q <= 1'b0;
        end
    end

    assign page_hit = row_vld_q && (req_row == row_q);
endmodule

// File: rtl/fpm_seq.sv
// Module: strobe sequencer. Accepts host requests, drives row and column
// strobes, captures read data and runs refresh with column strobes first.
// Assumes: timer and page tracker live outside; every timing value >= 1.
module fpm_seq
    import fpm_pkg::*;
#(
    parameter int ROW_BITS = 10,
    parameter int COL_BITS = 10,
    parameter int DW       = 16,
    parameter int T_RP     = 2,
    parameter int T_RCD    = 2,
    parameter int T_CAS    = 2,
    parameter int T_CP     = 1,
    parameter int T_REF    = 3,
    parameter int CW       = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [ROW_BITS+COL_BITS-1:0] req_addr,
    input  logic [DW-1:0]                req_wdata,
    input  logic [1:0]                   req_be,
    input  logic                         refresh_req,
    input  logic                         tmr_done,
    output logic                         tmr_ld,
    output logic [CW-1:0]                tmr_val,
    input  logic                         page_hit,
    output logic                         open_set,
    output logic                         open_clr,
    output logic [ROW_BITS-1:0]          open_row,
    output logic                         rd_valid,
    output logic [DW-1:0]                rd_data,
    output logic                         mem_ras_n,
    output logic                         mem_casl_n,
    output logic                         mem_cash_n,
    output logic                         mem_we_n,
    output logic [ROW_BITS-1:0]          mem_addr,
    output logic [DW-1:0]                mem_dq_out,
    output logic                         mem_dq_oe,
    input  logic [DW-1:0]                mem_dq_in
);
    localparam int LW  = DW / 2;
    localparam int HCW = $clog2(T_RP + 2) + 1;

    fpm_state_t          state_q, state_d;
    pre_tgt_t            tgt_q, tgt_d;
    logic                ref_pend_q;
    logic                wr_q;
    logic [ROW_BITS-1:0] row_q;
    logic [COL_BITS-1:0] col_q;
    logic [DW-1:0]       wd_q;
    logic [1:0]          be_q;
    logic                accept;
    logic [HCW-1:0]      ras_hi_q;

    assign req_ready = (state_q == S_IDLE || state_q == S_OPEN) && !ref_pend_q;
    assign accept    = req_ready && req_valid;

    // Next state, timer reload and precharge target.
    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        unique case (state_q)
            S_PRE: if (tmr_done) begin
                if (tgt_q == TGT_ACT) begin
                    state_d = S_ACT; tmr_ld = 1'b1; tmr_val = CW'(T_RCD - 1);
                end else if (tgt_q == TGT_REF) begin
                    state_d = S_RCAS;
                end else begin
                    state_d = S_IDLE;
                end
            end
            S_IDLE: if (ref_pend_q) begin
                state_d = S_RCAS;
            end else if (accept) begin
                state_d = S_ACT; tmr_ld = 1'b1; tmr_val = CW'(T_RCD - 1);
            end
            S_ACT: if (tmr_done) begin
                state_d = S_CAS; tmr_ld = 1'b1; tmr_val = CW'(T_CAS - 1);
            end
            S_CAS: if (tmr_done) begin
                state_d = S_CP; tmr_ld = 1'b1; tmr_val = CW'(T_CP - 1);
            end
            S_CP: if (tmr_done) state_d = S_OPEN;
            S_OPEN: if (ref_pend_q) begin
                state_d = S_PRE; tgt_d = TGT_REF;
                tmr_ld = 1'b1; tmr_val = CW'(T_RP - 1);
            end else if (accept) begin
                if (page_hit) begin
                    state_d = S_CAS; tmr_ld = 1'b1; tmr_val = CW'(T_CAS - 1);
                end else begin
                    state_d = S_PRE; tgt_d = TGT_ACT;
                    tmr_ld = 1'b1; tmr_val = CW'(T_RP - 1);
                end
            end
            S_RCAS: begin
                state_d = S_RRAS; tmr_ld = 1'b1; tmr_val = CW'(T_REF - 1);
            end
            S_RRAS: if (tmr_done) begin
                state_d = S_PRE; tgt_d = TGT_IDLE;
                tmr_ld = 1'b1; tmr_val = CW'(T_RP - 1);
            end
            default: state_d = S_PRE;
        endcase
    end

    // State, refresh pending flag and precharge target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_PRE;
            tgt_q      <= TGT_IDLE;
            ref_pend_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            tgt_q      <= tgt_d;
            ref_pend_q <= refresh_req || (ref_pend_q && state_q != S_RCAS);
        end
    end

    // Hold the accepted request for the strobe sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= 1'b0;
            row_q <= '0;
            col_q <= '0;
            wd_q  <= '0;
            be_q  <= '0;
        end else if (accept) begin
            wr_q  <= req_write;
            row_q <= req_addr[ROW_BITS+COL_BITS-1:COL_BITS];
            col_q <= req_addr[COL_BITS-1:0];
            wd_q  <= req_wdata;
            be_q  <= req_be;
        end
    end

    // Capture read data on the last column strobe cycle, masked by lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (state_q == S_CAS && tmr_done && !wr_q) begin
            rd_valid <= 1'b1;
            rd_data  <= mem_dq_in & {{LW{be_q[1]}}, {LW{be_q[0]}}};
        end else begin
            rd_valid <= 1'b0;
        end
    end

    // Count cycles with the row strobe high (checker support, saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)
            ras_hi_q <= '0;
        else if (!mem_ras_n)
            ras_hi_q <= '0;
        else if (ras_hi_q < HCW'(T_RP))
            ras_hi_q <= ras_hi_q + 1'b1;
    end

    assign mem_ras_n  = !(state_q inside {S_ACT, S_CAS, S_CP, S_OPEN, S_RRAS});
    assign mem_casl_n = !((state_q == S_CAS && be_q[0]) || state_q inside {S_RCAS, S_RRAS});
    assign mem_cash_n = !((state_q == S_CAS && be_q[1]) || state_q inside {S_RCAS, S_RRAS});
    assign mem_we_n   = !(state_q == S_CAS && wr_q);
    assign mem_dq_oe  = (state_q == S_CAS) && wr_q;
    assign mem_dq_out = wd_q;
    assign mem_addr   = (state_q == S_ACT) ? row_q : ROW_BITS'(col_q);
    assign open_set   = (state_q == S_ACT);
    assign open_clr   = (state_q == S_PRE) || (state_q == S_RRAS);
    assign open_row   = row_q;

    AST_REF_BOTH_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ras_n) && !mem_casl_n) |-> !mem_cash_n);   // R8
    AST_OE_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_ras_n));             // R11
    AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);                              // R7
    AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ras_n) |-> (ras_hi_q >= HCW'(T_RP)));        // R10
    AST_REF_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_casl_n && mem_ras_n) |-> !req_ready);           // R9
endmodule

// File: rtl/fpm_dram_ctrl.sv
// Module: top of the page mode DRAM controller. Connects the sequencer,
// the wait counter and the open-row tracker.
// Assumes: host address = {row, column}; all timing parameters >= 1.
module fpm_dram_ctrl #(
    parameter int ROW_BITS = 10,
    parameter int COL_BITS = 10,
    parameter int DW       = 16,
    parameter int T_RP     = 2,
    parameter int T_RCD    = 2,
    parameter int T_CAS    = 2,
    parameter int T_CP     = 1,
    parameter int T_REF    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [ROW_BITS+COL_BITS-1:0] req_addr,
    input  logic [DW-1:0]                req_wdata,
    input  logic [1:0]                   req_be,
    input  logic                         refresh_req,
    output logic                         rd_valid,
    output logic [DW-1:0]                rd_data,
    output logic                         mem_ras_n,
    output logic                         mem_casl_n,
    output logic                         mem_cash_n,
    output logic                         mem_we_n,
    output logic [ROW_BITS-1:0]          mem_addr,
    output logic [DW-1:0]                mem_dq_out,
    output logic                         mem_dq_oe,
    input  logic [DW-1:0]                mem_dq_in
);
    localparam int AW   = ROW_BITS + COL_BITS;
    localparam int TM1  = (T_RP > T_RCD) ? T_RP : T_RCD;
    localparam int TM2  = (T_CAS > T_CP) ? T_CAS : T_CP;
    localparam int TM3  = (TM1 > TM2) ? TM1 : TM2;
    localparam int TMAX = (TM3 > T_REF) ? TM3 : T_REF;
    localparam int CW   = $clog2(TMAX + 1) + 1;

    logic                tmr_done, tmr_ld;
    logic [CW-1:0]       tmr_val;
    logic                page_hit, open_set, open_clr;
    logic [ROW_BITS-1:0] open_row;

    fpm_wait_cnt #(.CW(CW), .RST_VAL(T_RP - 1)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .done(tmr_done)
    );

    fpm_page_track #(.ROW_BITS(ROW_BITS)) u_page (
        .clk(clk), .rst_n(rst_n), .open_set(open_set), .open_clr(open_clr),
        .set_row(open_row), .req_row(req_addr[AW-1:COL_BITS]), .page_hit(page_hit)
    );

    fpm_seq #(
        .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DW(DW), .T_RP(T_RP),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_REF(T_REF), .CW(CW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .refresh_req(refresh_req), .tmr_done(tmr_done),
        .tmr_ld(tmr_ld), .tmr_val(tmr_val), .page_hit(page_hit),
        .open_set(open_set), .open_clr(open_clr), .open_row(open_row),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_ras_n(mem_ras_n),
        .mem_casl_n(mem_casl_n), .mem_cash_n(mem_cash_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );
endmodule

// File: tb/tb_fpm_dram_ctrl.sv
// Bench: request table plus directed reset and refresh tests, against a
// behavioural memory model that reacts to strobe edges on the falling clock.
module tb_fpm_dram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int T_RP = 2, T_RCD = 2, T_CAS = 2, T_CP = 1, T_REF = 3;
    localparam int NVEC = 9;
    // {write, addr[19:0], wdata, be, expected read, expected row-strobe falls}
    localparam logic [56:0] VEC [NVEC] = '{
        {1'b1, 20'h00005, 16'hA5A5, 2'b11, 16'h0000, 2'd1},
        {1'b1, 20'h00006, 16'h1234, 2'b11, 16'h0000, 2'd0},
        {1'b0, 20'h00005, 16'h0000, 2'b11, 16'hA5A5, 2'd0},
        {1'b1, 20'h00005, 16'h7777, 2'b01, 16'h0000, 2'd0},
        {1'b0, 20'h00005, 16'h0000, 2'b11, 16'hA577, 2'd0},
        {1'b1, 20'h00C05, 16'hBEEF, 2'b10, 16'h0000, 2'd1},
        {1'b0, 20'h00C05, 16'h0000, 2'b10, 16'hBE00, 2'd0},
        {1'b0, 20'h00006, 16'h0000, 2'b11, 16'h1234, 2'd1},
        {1'b0, 20'h00005, 16'h0000, 2'b01, 16'h0077, 2'd0}
    };

    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_write = 0, refresh_req = 0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rd_valid;
    logic [15:0] rd_data;
    logic        mem_ras_n, mem_casl_n, mem_cash_n, mem_we_n, mem_dq_oe;
    logic [9:0]  mem_addr;
    logic [15:0] mem_dq_out, mem_dq_in;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int ras_falls = 0, ref_cnt = 0, rd_pulses = 0;
    logic [15:0] last_rd = '0;

    fpm_dram_ctrl #(.T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
                    .T_REF(T_REF)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .refresh_req(refresh_req), .rd_valid(rd_valid),
        .rd_data(rd_data), .mem_ras_n(mem_ras_n), .mem_casl_n(mem_casl_n),
        .mem_cash_n(mem_cash_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Behavioural memory model, evaluated on the falling clock edge.
    logic [15:0] mem [int];
    logic [9:0]  m_row = '0, m_col = '0;
    logic        p_ras = 1, p_cl = 1, p_ch = 1, in_ref = 0;
    int          ras_hi = 0, ras_lo = 0, cl_lo = 0, ch_lo = 0;
    logic [15:0] rd_word = '0;

    assign mem_dq_in = {(!mem_ras_n && !mem_cash_n && mem_we_n) ? rd_word[15:8] : 8'h00,
                        (!mem_ras_n && !mem_casl_n && mem_we_n) ? rd_word[7:0]  : 8'h00};

    always @(negedge clk) begin
        if (rst_n) begin
            int key;
            logic [15:0] w;
            if (!mem_ras_n && p_ras) begin
                chk("R10 row precharge", 32'(ras_hi >= T_RP), 1);
                if (!mem_casl_n && !mem_cash_n) begin
                    ref_cnt++; in_ref = 1;
                end else begin
                    chk("R8 no strobe low before row open", {p_cl, p_ch}, 2'b11);
                    m_row = mem_addr; ras_falls++;
                end
                ras_lo = 0;
            end
            if (mem_ras_n && !p_ras && in_ref) begin
                chk("R8 joint release", {mem_casl_n, mem_cash_n, p_cl, p_ch}, 4'b1100);
                in_ref = 0;
            end
            if (!mem_ras_n && ((!mem_casl_n && p_cl) || (!mem_cash_n && p_ch))) begin
                m_col = mem_addr;
                chk("R10 row-to-column delay", 32'(ras_lo >= T_RCD), 1);
                chk("R11 oe follows write", {mem_dq_oe, mem_we_n}, {!mem_we_n, mem_we_n});
                key = int'({m_row, m_col});
                w = mem.exists(key) ? mem[key] : 16'h0;
                if (!mem_we_n) begin
                    if (!mem_casl_n) w[7:0]  = mem_dq_out[7:0];
                    if (!mem_cash_n) w[15:8] = mem_dq_out[15:8];
                    mem[key] = w;
                end
                rd_word = w;
            end
            if (mem_casl_n && !p_cl && !in_ref && !mem_ras_n)
                chk("R10 column pulse width", 32'(cl_lo >= T_CAS), 1);
            if (mem_cash_n && !p_ch && !in_ref && !mem_ras_n)
                chk("R10 column pulse width", 32'(ch_lo >= T_CAS), 1);
            if (rd_valid) begin rd_pulses++; last_rd = rd_data; end
        end
        ras_hi = mem_ras_n ? ras_hi + 1 : 0;
        ras_lo = mem_ras_n ? 0 : ras_lo + 1;
        cl_lo  = mem_casl_n ? 0 : cl_lo + 1;
        ch_lo  = mem_cash_n ? 0 : ch_lo + 1;
        p_ras = mem_ras_n; p_cl = mem_casl_n; p_ch = mem_cash_n;
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic issue(input logic w, input logic [19:0] a, input logic [15:0] d,
                         input logic [1:0] be);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 0;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        int ready_hi;
        int falls0, pulses0;
        repeat (3) @(negedge clk);
        // R1: idle pin levels under reset
        chk("R1 strobes in reset", {mem_ras_n, mem_casl_n, mem_cash_n, mem_we_n}, 4'b1111);
        chk("R1 oe/valid in reset", {mem_dq_oe, rd_valid}, 2'b00);
        rst_n = 1;
        @(negedge clk);
        chk("R1 strobes after reset", {mem_ras_n, mem_casl_n, mem_cash_n, mem_we_n}, 4'b1111);
        chk("R1 oe/valid after reset", {mem_dq_oe, rd_valid}, 2'b00);

        // Table: R2 data path, R3 hits, R4 misses, R5/R6 lanes, R7 pulses
        for (int i = 0; i < NVEC; i++) begin
            falls0 = ras_falls; pulses0 = rd_pulses;
            issue(VEC[i][56], VEC[i][55:36], VEC[i][35:20], VEC[i][19:18]);
            chk("R3/R4 row strobe falls", 32'(ras_falls - falls0), 32'(VEC[i][1:0]));
            chk("R7 read-valid pulses", 32'(rd_pulses - pulses0), 32'(!VEC[i][56]));
            if (!VEC[i][56])
                chk("R2/R5/R6 read data", 32'(last_rd), 32'(VEC[i][17:2]));
        end

        // R9 and R8: refresh while a row is open
        @(negedge clk);
        refresh_req = 1;
        @(negedge clk);
        refresh_req = 0;
        ready_hi = 0;
        for (int k = 0; k < 6; k++) begin
            if (req_ready) ready_hi++;
            @(negedge clk);
        end
        chk("R9 ready low during refresh", 32'(ready_hi), 0);
        repeat (20) @(negedge clk);
        chk("R8 one refresh run", 32'(ref_cnt), 1);
        chk("R9 ready back after refresh", 32'(req_ready), 1);
        falls0 = ras_falls; pulses0 = rd_pulses;
        issue(1'b0, 20'h00005, 16'h0, 2'b11);
        chk("R8 page closed by refresh", 32'(ras_falls - falls0), 1);
        chk("R2 data kept across refresh", 32'(last_rd), 32'h0000A577);
        chk("R7 read-valid after refresh", 32'(rd_pulses - pulses0), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule